// File: doc/BRIEF.md
# Packet Retry and Reset Escalation Sequencer

This block sends one queued packet and watches for its acknowledge. It can retry the packet a set number of times. It can then escalate in two further steps: first to a soft reset packet, which has its own retries, and then to a hard reset. Software starts a transfer with a single-cycle start strobe and sets the policy through plain configuration pins:

- whether automatic retry is on,
- the retry count,
- whether a soft reset follows a data failure,
- whether a hard reset follows a soft reset failure.

The physical layer takes each send through a valid/ready handshake that carries the packet kind. The physical layer also reports, by single-cycle pulses, whether an acknowledge arrived or the acknowledge timer expired. The sequencer reports back through two sticky failure flags and five single-cycle interrupt pulses.

The send interface follows the valid/ready rule:

- A request, once raised, keeps its kind until ready is seen high in the same cycle.
- There are two exceptions. If the line is busy, the request is withdrawn and reported as a collision. If a hard reset command arrives, it takes the place of the request.
- The physical layer may hold ready low for as long as it needs.
- A hard reset request ignores the line-busy flag.

A hard reset command is accepted in every state and overrides whatever is in progress.

Top module: `pd_retry_ctrl`

## Requirements
- R1: After reset, snd_valid, every interrupt output and both failure flags are low.
- R2: A cmd_start pulse in the idle state raises snd_valid one cycle later with snd_kind = 2'b01 (data). The kind codes are data 01, soft reset 10 and hard reset 11. A cmd_start while a transfer is in progress is ignored.
- R3: While snd_valid is high and snd_ready is low, the next cycle keeps snd_valid high with the same snd_kind. The only exceptions are a busy line and a hard reset command.
- R4: With no acknowledge, a data packet is sent N+1 times when automatic retry is on and N is the 2-bit retry count, and once when automatic retry is off.
- R5: An ack_ok pulse while waiting raises irq_tx_sent for one cycle, ends the transfer, and produces no further sends.
- R6: When the last data attempt times out, retry_fail_flag sets and irq_retry_fail pulses.
- R7: With automatic soft reset on, a data failure is followed by soft reset packets under the same retry rule. When these are exhausted, soft_fail_flag sets and irq_soft_fail pulses.
- R8: With automatic hard reset on, a soft reset failure is followed by a hard reset request. irq_hard_sent pulses once that request is accepted.
- R9: A cmd_hard pulse in any state raises a hard reset request on the next cycle and abandons the transfer in progress.
- R10: An accepted cmd_start or any cmd_hard clears both failure flags by the next cycle.
- R11: If line_busy is high while a data or soft reset request is pending, no send occurs, irq_collision pulses, and the block returns to idle.
- R12: At most one interrupt output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Start strobe for the queued data packet |
| cmd_hard | input | 1 | Hard reset command strobe, highest priority |
| cfg_auto_retry | input | 1 | Enable automatic retries |
| cfg_retries | input | RETRY_W | Number of retries after the first attempt |
| cfg_auto_soft | input | 1 | Escalate to soft reset after data failure |
| cfg_auto_hard | input | 1 | Escalate to hard reset after soft reset failure |
| ack_ok | input | 1 | Acknowledge received pulse |
| ack_timeout | input | 1 | Acknowledge timer expired pulse |
| line_busy | input | 1 | Line activity present |
| snd_ready | input | 1 | Physical layer accepts the request |
| snd_valid | output | 1 | Send request |
| snd_kind | output | 2 | Packet kind of the request |
| retry_fail_flag | output | 1 | Sticky: data retries exhausted |
| soft_fail_flag | output | 1 | Sticky: soft reset retries exhausted |
| irq_tx_sent | output | 1 | Packet acknowledged |
| irq_retry_fail | output | 1 | Data retries exhausted |
| irq_soft_fail | output | 1 | Soft reset retries exhausted |
| irq_hard_sent | output | 1 | Hard reset request accepted |
| irq_collision | output | 1 | Send abandoned on a busy line |

## Verification
The bench builds the block with the default RETRY_W of 2. At that width it can sweep every combination of retry count, retry enable, soft escalation and hard escalation. For each combination it also tries every attempt index at which the acknowledge may arrive, plus the case with no acknowledge at all. Every path through the escalation chain is therefore covered, and the send counts are predicted arithmetically. Directed cases add:

- back-pressure on the send handshake,
- collision on a busy line,
- a hard reset that pre-empts a wait for acknowledge,
- a start command ignored mid-transfer.

// File: rtl/pd_retry_pkg.sv
package pd_retry_pkg;
  typedef enum logic [1:0] {
    PK_NONE = 2'd0,
    PK_DATA = 2'd1,
    PK_SOFT = 2'd2,
    PK_HARD = 2'd3
  } pkt_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_HARD = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic tx_sent;
    logic retry_fail;
    logic soft_fail;
    logic hard_sent;
    logic collision;
  } seq_evt_t;
endpackage

// File: rtl/pd_retry_counter.sv
module pd_retry_counter #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic         spent
);
  logic [W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count_q <= '0;
    else if (clr)
      count_q <= '0;
    else if (inc && !spent)
      count_q <= count_q + 1'b1;
  end

  assign spent = (count_q >= limit);
endmodule

// File: rtl/pd_retry_fsm.sv
module pd_retry_fsm
  import pd_retry_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmd_start,
  input  logic      cmd_hard,
  input  logic      cfg_auto_soft,
  input  logic      cfg_auto_hard,
  input  logic      ack_ok,
  input  logic      ack_timeout,
  input  logic      line_busy,
  input  logic      snd_ready,
  input  logic      spent,
  output logic      snd_valid,
  output pkt_kind_e snd_kind,
  output logic      cnt_clr,
  output logic      cnt_inc,
  output logic      clr_flags,
  output seq_evt_t  evt
);
  seq_state_e state_q, state_d;
  pkt_kind_e  kind_q, kind_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= PK_DATA;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
    end
  end

  always_comb begin
    state_d   = state_q;
    kind_d    = kind_q;
    snd_valid = 1'b0;
    snd_kind  = PK_NONE;
    cnt_clr   = 1'b0;
    cnt_inc   = 1'b0;
    clr_flags = 1'b0;
    evt       = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_hard) begin
          state_d   = ST_HARD;
          clr_flags = 1'b1;
        end else if (cmd_start) begin
          state_d   = ST_REQ;
          kind_d    = PK_DATA;
          cnt_clr   = 1'b1;
          clr_flags = 1'b1;
        end
      end
      ST_REQ: begin
        snd_valid = !line_busy;
        snd_kind  = line_busy ? PK_NONE : kind_q;
        if (cmd_hard) begin
          state_d   = ST_HARD;
          clr_flags = 1'b1;
        end else if (line_busy) begin
          evt.collision = 1'b1;
          state_d       = ST_IDLE;
        end else if (snd_ready) begin
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (cmd_hard) begin
          state_d   = ST_HARD;
          clr_flags = 1'b1;
        end else if (ack_ok) begin
          evt.tx_sent = 1'b1;
          state_d     = ST_IDLE;
        end else if (ack_timeout) begin
          if (!spent) begin
            cnt_inc = 1'b1;
            state_d = ST_REQ;
          end else if (kind_q == PK_DATA) begin
            evt.retry_fail = 1'b1;
            if (cfg_auto_soft) begin
              kind_d  = PK_SOFT;
              cnt_clr = 1'b1;
              state_d = ST_REQ;
            end else begin
              state_d = ST_IDLE;
            end
          end else begin
            evt.soft_fail = 1'b1;
            state_d = cfg_auto_hard ? ST_HARD : ST_IDLE;
          end
        end
      end
      ST_HARD: begin
        snd_valid = 1'b1;
        snd_kind  = PK_HARD;
        if (cmd_hard)
          clr_flags = 1'b1;
        if (snd_ready) begin
          evt.hard_sent = 1'b1;
          state_d = cmd_hard ? ST_HARD : ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/pd_retry_status.sv
module pd_retry_status
  import pd_retry_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  seq_evt_t evt,
  input  logic     clr_flags,
  output logic     retry_fail_flag,
  output logic     soft_fail_flag,
  output seq_evt_t irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq             <= '0;
      retry_fail_flag <= 1'b0;
      soft_fail_flag  <= 1'b0;
    end else begin
      irq <= evt;
      if (clr_flags) begin
        retry_fail_flag <= 1'b0;
        soft_fail_flag  <= 1'b0;
      end else begin
        if (evt.retry_fail) retry_fail_flag <= 1'b1;
        if (evt.soft_fail)  soft_fail_flag  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pd_retry_ctrl.sv
module pd_retry_ctrl
  import pd_retry_pkg::*;
#(
  parameter int RETRY_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_start,
  input  logic               cmd_hard,
  input  logic               cfg_auto_retry,
  input  logic [RETRY_W-1:0] cfg_retries,
  input  logic               cfg_auto_soft,
  input  logic               cfg_auto_hard,
  input  logic               ack_ok,
  input  logic               ack_timeout,
  input  logic               line_busy,
  input  logic               snd_ready,
  output logic               snd_valid,
  output logic [1:0]         snd_kind,
  output logic               retry_fail_flag,
  output logic               soft_fail_flag,
  output logic               irq_tx_sent,
  output logic               irq_retry_fail,
  output logic               irq_soft_fail,
  output logic               irq_hard_sent,
  output logic               irq_collision
);
  logic [RETRY_W-1:0] limit;
  logic               spent, cnt_clr, cnt_inc, clr_flags;
  pkt_kind_e          kind;
  seq_evt_t           evt, irq;

  assign limit = cfg_auto_retry ? cfg_retries : '0;

  pd_retry_counter #(.W(RETRY_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc),
    .limit(limit), .spent(spent)
  );

  pd_retry_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_hard(cmd_hard),
    .cfg_auto_soft(cfg_auto_soft), .cfg_auto_hard(cfg_auto_hard),
    .ack_ok(ack_ok), .ack_timeout(ack_timeout), .line_busy(line_busy),
    .snd_ready(snd_ready), .spent(spent), .snd_valid(snd_valid),
    .snd_kind(kind), .cnt_clr(cnt_clr), .cnt_inc(cnt_inc),
    .clr_flags(clr_flags), .evt(evt)
  );

  pd_retry_status u_stat (
    .clk(clk), .rst_n(rst_n), .evt(evt), .clr_flags(clr_flags),
    .retry_fail_flag(retry_fail_flag), .soft_fail_flag(soft_fail_flag),
    .irq(irq)
  );

  assign snd_kind       = kind;
  assign irq_tx_sent    = irq.tx_sent;
  assign irq_retry_fail = irq.retry_fail;
  assign irq_soft_fail  = irq.soft_fail;
  assign irq_hard_sent  = irq.hard_sent;
  assign irq_collision  = irq.collision;
endmodule

// File: rtl/pd_retry_ctrl_chk.sv
module pd_retry_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_hard,
  input logic       line_busy,
  input logic       snd_valid,
  input logic       snd_ready,
  input logic [1:0] snd_kind,
  input logic       retry_fail_flag,
  input logic       soft_fail_flag,
  input logic       irq_tx_sent,
  input logic       irq_retry_fail,
  input logic       irq_soft_fail,
  input logic       irq_hard_sent,
  input logic       irq_collision
);
  assert_hard_preempt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hard |=> (snd_valid && snd_kind == 2'b11));

  assert_hard_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_valid && !snd_ready && snd_kind == 2'b11) |=> (snd_valid && $stable(snd_kind)));

  assert_flags_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hard |=> (!retry_fail_flag && !soft_fail_flag));

  assert_retry_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_retry_fail |-> retry_fail_flag);

  assert_soft_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_soft_fail |-> soft_fail_flag);

  assert_collision_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_collision |-> $past(line_busy));

  assert_one_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_tx_sent, irq_retry_fail, irq_soft_fail, irq_hard_sent, irq_collision}));

  assert_kind_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    snd_valid |-> (snd_kind != 2'b00));
endmodule

bind pd_retry_ctrl pd_retry_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_hard(cmd_hard), .line_busy(line_busy),
  .snd_valid(snd_valid), .snd_ready(snd_ready), .snd_kind(snd_kind),
  .retry_fail_flag(retry_fail_flag), .soft_fail_flag(soft_fail_flag),
  .irq_tx_sent(irq_tx_sent), .irq_retry_fail(irq_retry_fail),
  .irq_soft_fail(irq_soft_fail), .irq_hard_sent(irq_hard_sent),
  .irq_collision(irq_collision)
);

// File: tb/pd_retry_ctrl_tb.sv
module pd_retry_ctrl_tb;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cmd_start = 0, cmd_hard = 0, cfg_auto_retry = 0, cfg_auto_soft = 0, cfg_auto_hard = 0;
  logic [1:0] cfg_retries = 0;
  logic ack_ok = 0, ack_timeout = 0, line_busy = 0, snd_ready = 0;
  logic snd_valid, retry_fail_flag, soft_fail_flag;
  logic [1:0] snd_kind;
  logic irq_tx_sent, irq_retry_fail, irq_soft_fail, irq_hard_sent, irq_collision;

  int n_run = 0, n_fail = 0;
  int c_data = 0, c_soft = 0, c_hard = 0;
  int c_tx = 0, c_rf = 0, c_sf = 0, c_hs = 0, c_col = 0;

  always #(PERIOD/2) clk = ~clk;

  pd_retry_ctrl #(.RETRY_W(2)) u_dut (.*);

  always @(posedge clk) begin
    if (snd_valid && snd_ready) begin
      if (snd_kind == 2'b01) c_data++;
      if (snd_kind == 2'b10) c_soft++;
      if (snd_kind == 2'b11) c_hard++;
    end
    if (irq_tx_sent) c_tx++;
    if (irq_retry_fail) c_rf++;
    if (irq_soft_fail) c_sf++;
    if (irq_hard_sent) c_hs++;
    if (irq_collision) c_col++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic serve(input int ack_at);
    int att = 0, idle = 0;
    logic [1:0] k;
    while (idle < 6) begin
      if (snd_valid) begin
        k = snd_kind;
        snd_ready = 1;
        @(negedge clk);
        snd_ready = 0;
        if (k != 2'b11) begin
          repeat (2) @(negedge clk);
          if (k == 2'b01 && att == ack_at) ack_ok = 1; else ack_timeout = 1;
          if (k == 2'b01) att++;
          @(negedge clk);
          ack_ok = 0; ack_timeout = 0;
        end
        idle = 0;
      end else begin
        @(negedge clk);
        idle++;
      end
    end
  endtask

  task automatic run_seq(input bit ar, input int rc, input bit as_, input bit ah, input int ack_at);
    int d0, s0, h0, t0, r0, f0, hs0;
    int n, ed, es, eh, et, er, ef;
    cfg_auto_retry = ar; cfg_retries = rc[1:0]; cfg_auto_soft = as_; cfg_auto_hard = ah;
    d0 = c_data; s0 = c_soft; h0 = c_hard; t0 = c_tx; r0 = c_rf; f0 = c_sf; hs0 = c_hs;
    cmd_start = 1;
    @(negedge clk);
    cmd_start = 0;
    // R10: flags cleared after accepted start; R2: data request raised
    chk(!retry_fail_flag && !soft_fail_flag, "R10 flags clear on start", {retry_fail_flag, soft_fail_flag}, 0);
    chk(snd_valid && snd_kind == 2'b01, "R2 data request after start", snd_kind, 1);
    serve(ack_at);
    n = ar ? rc + 1 : 1;
    if (ack_at < n) begin
      ed = ack_at + 1; es = 0; eh = 0; et = 1; er = 0; ef = 0;
    end else begin
      ed = n; et = 0; er = 1;
      es = as_ ? n : 0; ef = as_ ? 1 : 0; eh = (as_ && ah) ? 1 : 0;
    end
    chk(c_data - d0 == ed, "R4 data send count", c_data - d0, ed);
    chk(c_tx - t0 == et, "R5 tx_sent irq count", c_tx - t0, et);
    chk(c_rf - r0 == er && retry_fail_flag == er[0], "R6 retry fail irq/flag", c_rf - r0, er);
    chk(c_soft - s0 == es, "R7 soft send count", c_soft - s0, es);
    chk(c_sf - f0 == ef && soft_fail_flag == ef[0], "R7 soft fail irq/flag", c_sf - f0, ef);
    chk(c_hard - h0 == eh && c_hs - hs0 == eh, "R8 auto hard reset", c_hard - h0, eh);
  endtask

  initial begin
    #(PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    int d0, h0, c0, t0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!snd_valid && !retry_fail_flag && !soft_fail_flag &&
        !irq_tx_sent && !irq_retry_fail && !irq_soft_fail && !irq_hard_sent && !irq_collision,
        "R1 reset outputs", snd_valid, 0);
    rst_n = 1;
    @(negedge clk);

    // Full sweep of the escalation chain
    for (int ar = 0; ar < 2; ar++)
      for (int rc = 0; rc < 4; rc++)
        for (int as_ = 0; as_ < 2; as_++)
          for (int ah = 0; ah < 2; ah++)
            for (int aa = 0; aa < 5; aa++)
              run_seq(ar[0], rc, as_[0], ah[0], aa);

    // R3: back-pressure holds request and kind
    cfg_auto_retry = 0;
    cmd_start = 1; @(negedge clk); cmd_start = 0;
    for (int i = 0; i < 5; i++) begin
      chk(snd_valid && snd_kind == 2'b01, "R3 request held under back-pressure", snd_kind, 1);
      @(negedge clk);
    end
    t0 = c_tx; d0 = c_data;
    snd_ready = 1; @(negedge clk); snd_ready = 0;
    // R2: start ignored while waiting
    cmd_start = 1; @(negedge clk); cmd_start = 0;
    ack_ok = 1; @(negedge clk); ack_ok = 0;
    repeat (4) @(negedge clk);
    chk(c_data - d0 == 1 && !snd_valid, "R2 start ignored mid-transfer", c_data - d0, 1);
    chk(c_tx - t0 == 1, "R5 ack ends transfer", c_tx - t0, 1);

    // R11: collision on busy line
    c0 = c_col; d0 = c_data;
    line_busy = 1;
    cmd_start = 1; @(negedge clk); cmd_start = 0;
    @(negedge clk);
    chk(irq_collision, "R11 collision irq", irq_collision, 1);
    chk(!snd_valid && c_data == d0, "R11 no send on busy line", c_data - d0, 0);
    line_busy = 0;
    repeat (3) @(negedge clk);
    chk(c_col - c0 == 1 && !snd_valid, "R11 back to idle", c_col - c0, 1);

    // R9: hard reset pre-empts wait for acknowledge; R10 clears flag
    cfg_auto_retry = 1; cfg_retries = 2'd3; cfg_auto_soft = 0;
    run_seq(1'b0, 0, 1'b0, 1'b0, 4);  // leaves retry_fail_flag set
    cfg_auto_retry = 1; cfg_retries = 2'd3;
    cmd_start = 1; @(negedge clk); cmd_start = 0;
    snd_ready = 1; @(negedge clk); snd_ready = 0;
    h0 = c_hs; t0 = c_tx;
    cmd_hard = 1; @(negedge clk); cmd_hard = 0;
    chk(snd_valid && snd_kind == 2'b11, "R9 hard request pre-empts", snd_kind, 3);
    chk(!retry_fail_flag && !soft_fail_flag, "R10 flags clear on hard", retry_fail_flag, 0);
    snd_ready = 1; @(negedge clk); snd_ready = 0;
    chk(irq_hard_sent, "R8 hard sent irq", irq_hard_sent, 1);
    ack_ok = 1; @(negedge clk); ack_ok = 0;
    repeat (3) @(negedge clk);
    chk(c_hs - h0 == 1 && c_tx == t0 && !snd_valid, "R9 transfer abandoned", c_tx - t0, 0);

    // R12: a single irq at a time is also checked by the pulse counts above
    chk(!(irq_tx_sent && irq_hard_sent), "R12 single irq", irq_tx_sent, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule